// File: doc/BRIEF.md
# External Interrupt Line Conditioner

This block sits between a set of asynchronous interrupt pins and an internal interrupt controller. It gives the controller one clean active-high request per line and one combined request. Each pin first passes through a two-flop synchronizer. Each line can then be set to one of four senses: a high level, a low level, a rising edge or a falling edge. Edge events are held in a per-line pending latch until software acknowledges them. Level requests follow the pin directly and are never latched.

Software sees the block through a plain synchronous register port: an address, a write strobe, a read strobe and write data, with read data registered one cycle after the read strobe. Three configuration registers hold the sense of each line. Masking uses write-one-to-set and write-one-to-clear strobes, so one line can be changed without a read-modify-write. A write-one-to-clear acknowledge removes latched edge events. Line i is bit i in every register. Configuration bits at or above the number of lines read back as zero, so software can find the line count by writing all ones and reading back. The block has no streaming data path, so all of its pins are plain control and status signals.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset every line is masked and configured as falling-edge. No events are pending, `irq_out` and `irq_any` are low, and reads of offsets 0 to 5 return zero.
- R2: Offset 0 is the sense-type register (1 = level, 0 = edge) and reads back what was written, but only for bits below NUM_LINES. Writing all ones and reading back gives 2^NUM_LINES - 1.
- R3: For an edge-mode line with offset 1 bit set to 1, a rising pin edge latches a pending event. The output rises three clock edges after the pin changes: two synchronizer stages plus the latch.
- R4: For an edge-mode line with offset 1 bit set to 0, only a falling pin edge latches an event, and a rising edge has no effect. A latched event stays set after the pin returns.
- R5: A level-mode line is pending while its synchronized pin equals its offset 2 polarity bit (1 = active-high, 0 = active-low), two clock edges after the pin changes. An acknowledge has no lasting effect while the level stays active.
- R6: A write to offset 3 unmasks each line whose data bit is 1. Bits written as 0 leave the mask unchanged. A read of offset 3 returns the enable mask.
- R7: A write to offset 4 masks each line whose data bit is 1. Bits written as 0 leave the mask unchanged. A read of offset 4 returns the enable mask.
- R8: A write to offset 5 clears the latched edge event of each line whose data bit is 1. When a new qualifying edge and an acknowledge for the same line arrive in the same cycle, the line stays pending.
- R9: `irq_out[i]` is high exactly when line i is pending and enabled. `irq_any` is the OR of all bits of `irq_out`.
- R10: A read of offset 5 returns the pending state of every line, including masked lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the synchronizers and registers are clocked by clk |
| irq_pin | input | NUM_LINES | Asynchronous external interrupt pins |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; reg_rdata is valid in the next cycle |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq_out | output | NUM_LINES | Per-line active-high requests to the interrupt controller |
| irq_any | output | 1 | OR of all bits of irq_out |

## Verification
The bench compares `irq_out`, `irq_any` and `reg_rdata` with a reference model on every clock. Any latency error in the synchronizer or the event latch therefore shows up as a one-cycle mismatch. Directed cases cover the following:
- A rising edge on a falling-edge line. A design that ignores the direction bit would raise a request here.
- An acknowledge of an active level line. A design that latches level requests would drop the request here.
- An acknowledge that lands in the same cycle as a new edge. A design that gives the clear priority would lose the event.
- The all-ones write to the sense-type register. A design with unimplemented storage bits would report a wrong line count.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_SENSE  = 3'd0,
    REG_DIR    = 3'd1,
    REG_POL    = 3'd2,
    REG_UNMASK = 3'd3,
    REG_MASK   = 3'd4,
    REG_ACK    = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= din;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/ext_irq_line.sv
module ext_irq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic sense_lvl,
  input  logic dir_rise,
  input  logic pol_high,
  input  logic ack,
  output logic pend
);
  logic prev_q;
  logic latch_q;
  logic evt;
  logic active;

  assign evt    = dir_rise ? (pin_s & ~prev_q) : (~pin_s & prev_q);
  assign active = pol_high ? pin_s : ~pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= pin_s;
      latch_q <= sense_lvl ? 1'b0 : ((latch_q & ~ack) | evt);
    end
  end

  assign pend = sense_lvl ? active : latch_q;

  assert_edge_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sense_lvl && evt) |=> latch_q);

  assert_edge_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sense_lvl && latch_q && !ack) |=> latch_q);

  assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sense_lvl && ack && !evt) |=> !latch_q);

  assert_level_no_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sense_lvl |=> !latch_q);
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic                  wr,
  input  logic                  rd,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [NUM_LINES-1:0]  pending,
  output logic [NUM_LINES-1:0]  sense_q,
  output logic [NUM_LINES-1:0]  dir_q,
  output logic [NUM_LINES-1:0]  pol_q,
  output logic [NUM_LINES-1:0]  mask_q,
  output logic [NUM_LINES-1:0]  ack,
  output logic [DATA_W-1:0]     rdata
);
  logic [NUM_LINES-1:0] wbits;
  logic [DATA_W-1:0]    rd_mux;

  assign wbits = wdata[NUM_LINES-1:0];

  generate
    if (DATA_W > NUM_LINES) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wdata[DATA_W-1:NUM_LINES];
    end
  endgenerate

  assign ack = (wr && addr == REG_ACK) ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      dir_q   <= '0;
      pol_q   <= '0;
      mask_q  <= '0;
    end else if (wr) begin
      case (addr)
        REG_SENSE:  sense_q <= wbits;
        REG_DIR:    dir_q   <= wbits;
        REG_POL:    pol_q   <= wbits;
        REG_UNMASK: mask_q  <= mask_q | wbits;
        REG_MASK:   mask_q  <= mask_q & ~wbits;
        default:    ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      REG_SENSE:  rd_mux[NUM_LINES-1:0] = sense_q;
      REG_DIR:    rd_mux[NUM_LINES-1:0] = dir_q;
      REG_POL:    rd_mux[NUM_LINES-1:0] = pol_q;
      REG_UNMASK,
      REG_MASK:   rd_mux[NUM_LINES-1:0] = mask_q;
      REG_ACK:    rd_mux[NUM_LINES-1:0] = pending;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

  assert_enable_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == REG_UNMASK) |=>
      (((mask_q & $past(wbits)) == $past(wbits)) &&
       ((mask_q & ~$past(wbits)) == ($past(mask_q) & ~$past(wbits)))));

  assert_disable_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == REG_MASK) |=>
      (((mask_q & $past(wbits)) == '0) &&
       ((mask_q & ~$past(wbits)) == ($past(mask_q) & ~$past(wbits)))));

  assert_pending_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == REG_ACK) |=> (rdata[NUM_LINES-1:0] == $past(pending)));
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  irq_pin,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic [NUM_LINES-1:0]  irq_out,
  output logic                  irq_any
);
  logic [NUM_LINES-1:0] pin_s;
  logic [NUM_LINES-1:0] sense_q;
  logic [NUM_LINES-1:0] dir_q;
  logic [NUM_LINES-1:0] pol_q;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] ack;
  logic [NUM_LINES-1:0] pend;

  ext_irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (irq_pin),
    .dout (pin_s)
  );

  ext_irq_regs #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) regs_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (reg_addr),
    .wr     (reg_wr),
    .rd     (reg_rd),
    .wdata  (reg_wdata),
    .pending(pend),
    .sense_q(sense_q),
    .dir_q  (dir_q),
    .pol_q  (pol_q),
    .mask_q (mask_q),
    .ack    (ack),
    .rdata  (reg_rdata)
  );

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      ext_irq_line line_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_s    (pin_s[i]),
        .sense_lvl(sense_q[i]),
        .dir_rise (dir_q[i]),
        .pol_high (pol_q[i]),
        .ack      (ack[i]),
        .pend     (pend[i])
      );
    end
  endgenerate

  assign irq_out = pend & mask_q;
  assign irq_any = |irq_out;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask_q == '0));
endmodule

// File: tb/ext_irq_cond_tb_top.sv
module ext_irq_cond_tb_top;
  localparam int N  = 8;
  localparam int DW = 32;
  localparam logic [2:0] A_SENSE = 3'd0, A_DIR = 3'd1, A_POL = 3'd2,
                         A_EN = 3'd3, A_DIS = 3'd4, A_ACK = 3'd5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_pin = '0;
  logic [2:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [N-1:0]  irq_out;
  logic          irq_any;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ext_irq_cond #(.NUM_LINES(N), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out), .irq_any(irq_any)
  );

  // Behavioural reference: pin delay history, configuration, latched events.
  logic [N-1:0]  m_h1, m_h2, m_h3;
  logic [N-1:0]  m_sense, m_dir, m_pol, m_mask, m_latch;
  logic [DW-1:0] m_rdata;

  function automatic logic [N-1:0] m_pending();
    logic [N-1:0] p;
    for (int i = 0; i < N; i++)
      p[i] = m_sense[i] ? (m_h2[i] == m_pol[i]) : m_latch[i];
    return p;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_h1 = '0; m_h2 = '0; m_h3 = '0;
      m_sense = '0; m_dir = '0; m_pol = '0; m_mask = '0; m_latch = '0;
      m_rdata = '0;
    end else begin
      logic [N-1:0] pnow;
      logic [N-1:0] clr;
      logic [N-1:0] nlatch;
      pnow = m_pending();
      clr = (reg_wr && reg_addr == A_ACK) ? reg_wdata[N-1:0] : '0;
      for (int i = 0; i < N; i++) begin
        bit hit;
        hit = m_dir[i] ? (m_h2[i] && !m_h3[i]) : (!m_h2[i] && m_h3[i]);
        if (m_sense[i]) nlatch[i] = 1'b0;
        else if (hit) nlatch[i] = 1'b1;
        else if (clr[i]) nlatch[i] = 1'b0;
        else nlatch[i] = m_latch[i];
      end
      if (reg_rd) begin
        m_rdata = '0;
        case (reg_addr)
          A_SENSE: m_rdata[N-1:0] = m_sense;
          A_DIR:   m_rdata[N-1:0] = m_dir;
          A_POL:   m_rdata[N-1:0] = m_pol;
          A_EN, A_DIS: m_rdata[N-1:0] = m_mask;
          A_ACK:   m_rdata[N-1:0] = pnow;
          default: m_rdata = '0;
        endcase
      end
      if (reg_wr) begin
        case (reg_addr)
          A_SENSE: m_sense = reg_wdata[N-1:0];
          A_DIR:   m_dir = reg_wdata[N-1:0];
          A_POL:   m_pol = reg_wdata[N-1:0];
          A_EN:    m_mask = m_mask | reg_wdata[N-1:0];
          A_DIS:   m_mask = m_mask & ~reg_wdata[N-1:0];
          default: ;
        endcase
      end
      m_latch = nlatch;
      m_h3 = m_h2; m_h2 = m_h1; m_h1 = irq_pin;
    end
  end

  // Every-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [N-1:0] exp_out;
      exp_out = m_pending() & m_mask;
      checks++;
      if (irq_out !== exp_out) begin
        errors++;
        $display("FAIL R3 R4 R5 R9 irq_out actual=%h expected=%h t=%0t", irq_out, exp_out, $time);
      end
      checks++;
      if (irq_any !== (|exp_out)) begin
        errors++;
        $display("FAIL R9 irq_any actual=%b expected=%b t=%0t", irq_any, |exp_out, $time);
      end
      checks++;
      if (reg_rdata !== m_rdata) begin
        errors++;
        $display("FAIL R2 R6 R7 R10 reg_rdata actual=%h expected=%h t=%0t", reg_rdata, m_rdata, $time);
      end
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [DW-1:0] d);
    @(posedge clk); #2;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #2;
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [DW-1:0] exp, input string tag);
    @(posedge clk); #2;
    reg_addr = a; reg_rd = 1'b1;
    @(posedge clk); #2;
    reg_rd = 1'b0;
    @(negedge clk);
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s read offset %0d actual=%h expected=%h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic set_pin(input logic [N-1:0] v);
    @(posedge clk); #2;
    irq_pin = v;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic bit_chk(input int idx, input logic exp, input string tag);
    @(negedge clk);
    checks++;
    if (irq_out[idx] !== exp) begin
      errors++;
      $display("FAIL %s irq_out[%0d] actual=%b expected=%b", tag, idx, irq_out[idx], exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 reset state
    @(negedge clk);
    checks++;
    if (irq_out !== '0 || irq_any !== 1'b0) begin
      errors++;
      $display("FAIL R1 outputs actual=%h/%b expected=0/0", irq_out, irq_any);
    end
    for (int a = 0; a < 6; a++) rd_chk(3'(a), '0, "R1");

    // R2 line-count discovery
    wr_reg(A_SENSE, '1);
    rd_chk(A_SENSE, 32'h0000_00FF, "R2");
    wr_reg(A_SENSE, '0);
    rd_chk(A_SENSE, '0, "R2");

    // R3 rising edge on line 0
    wr_reg(A_DIR, 32'h01);
    wr_reg(A_EN, 32'h01);
    rd_chk(A_EN, 32'h01, "R6");
    set_pin(8'h01);
    wait_cyc(4);
    bit_chk(0, 1'b1, "R3");
    set_pin(8'h00);
    wait_cyc(4);
    bit_chk(0, 1'b1, "R4 latched after pin returns");
    wr_reg(A_ACK, 32'h01);
    bit_chk(0, 1'b0, "R8");

    // R4 falling edge on line 1
    wr_reg(A_EN, 32'h02);
    set_pin(8'h02);
    wait_cyc(4);
    bit_chk(1, 1'b0, "R4 rising ignored");
    set_pin(8'h00);
    wait_cyc(4);
    bit_chk(1, 1'b1, "R4");
    rd_chk(A_ACK, 32'h02, "R10");
    wr_reg(A_ACK, 32'h02);
    bit_chk(1, 1'b0, "R8");

    // R5 level active-high on line 2
    wr_reg(A_POL, 32'h04);
    wr_reg(A_SENSE, 32'h04);
    wr_reg(A_EN, 32'h04);
    set_pin(8'h04);
    wait_cyc(3);
    bit_chk(2, 1'b1, "R5");
    wr_reg(A_ACK, 32'h04);
    wait_cyc(1);
    bit_chk(2, 1'b1, "R5 ack no lasting effect");
    set_pin(8'h00);
    wait_cyc(3);
    bit_chk(2, 1'b0, "R5");

    // R5 level active-low on line 3 (pin already low)
    wr_reg(A_SENSE, 32'h0C);
    wr_reg(A_EN, 32'h08);
    bit_chk(3, 1'b1, "R5 active-low");

    // R6 zero bits leave mask; R7 disable; R10 masked still visible
    wr_reg(A_EN, 32'h00);
    rd_chk(A_EN, 32'h0F, "R6");
    wr_reg(A_DIS, 32'h08);
    bit_chk(3, 1'b0, "R7");
    rd_chk(A_DIS, 32'h07, "R7");
    rd_chk(A_ACK, 32'h08, "R10");
    set_pin(8'h08);
    wait_cyc(3);
    rd_chk(A_ACK, 32'h00, "R5 active-low released");

    // R8 same-cycle edge and acknowledge on line 0
    set_pin(8'h09);
    @(posedge clk);
    wr_reg(A_ACK, 32'h01);
    bit_chk(0, 1'b1, "R8 edge wins over ack");
    wait_cyc(2);
    bit_chk(0, 1'b1, "R8");
    wr_reg(A_ACK, 32'h01);
    bit_chk(0, 1'b0, "R8");

    // R9 summary with several lines
    wr_reg(A_EN, 32'hFF);
    set_pin(8'h00);
    wait_cyc(4);
    @(negedge clk);
    checks++;
    if (irq_any !== (|irq_out) || irq_out[3] !== 1'b1) begin
      errors++;
      $display("FAIL R9 irq_any=%b irq_out=%h expected any=1 bit3=1", irq_any, irq_out);
    end

    wait_cyc(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule